// File: doc/BRIEF.md
# Two-Window Overlay Compositor

This block decides, for each pixel coordinate of a scan, which of two rectangular windows covers it and produces the composited RGB888 colour. Window 0 is the base layer and window 1 is drawn on top of it, for example a cursor. The pixel words for both windows arrive already fetched, in the same cycle as the coordinate. The block pulls the colour and the alpha byte out of each word according to the window's two-bit format code, and then blends the windows in order over a black background.

Each window is placed by an origin and a size. The block turns these into an inclusive bottom-right corner itself. A window whose format has no alpha byte uses a constant alpha, which is opaque by default. Only the upper window has a colour key: where that key is enabled and matches, the upper window is transparent. The result is registered, so it appears one clock after the coordinate.

There is no sequencing state. The datapath is combinational from the inputs to a single output register.

Top module: `overlay_mixer`

## Requirements
- R1: A window's inclusive right column is origin X plus width minus one. Its inclusive bottom row is origin Y plus height minus one. When origin plus size is zero on an axis, the corner on that axis is zero, so a window at origin 0 with size 0 covers pixel (0,0) only.
- R2: A window covers a pixel when the window is enabled and the pixel lies inside or on all four edges of its rectangle. The first column or row past any edge is not covered.
- R3: A pixel covered by no enabled, unkeyed window outputs black (0x000000).
- R4: Where both windows cover a pixel and window 1 is opaque, the output is the colour of window 1.
- R5: Format code bit 0 set means the word carries a per-pixel alpha. Bit 1 clear places alpha or padding in bits [31:24] with R,G,B in [23:16],[15:8],[7:0]. Bit 1 set places it in bits [7:0] with R,G,B in [31:24],[23:16],[15:8]. A format without alpha ignores that byte and uses CONST_ALPHA (default 0xFF).
- R6: Window 1 is blended over the window-0 result per channel as (a*top + (255-a)*bottom + 127)/255, with integer division.
- R7: Window 0 is blended with the same formula over a black background.
- R8: When the key enable is 1 and the window-1 RGB equals the key colour, window 1 does not cover that pixel. Window 0 has no key.
- R9: With the key enable at 0, the key colour has no effect, including a key of 0xFFFFFF on a white window-1 pixel.
- R10: The output colour and out_valid are registered one clock after the inputs, and out_valid equals the in_valid of the previous cycle. While reset is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coordinate and pixel words are valid |
| pos_x | input | COORD_W | Current pixel column |
| pos_y | input | COORD_W | Current pixel row |
| w0_en | input | 1 | Window 0 enable |
| w0_fmt | input | 2 | Window 0 format code |
| w0_x | input | COORD_W | Window 0 origin column |
| w0_y | input | COORD_W | Window 0 origin row |
| w0_w | input | COORD_W | Window 0 width |
| w0_h | input | COORD_W | Window 0 height |
| w0_pix | input | 32 | Window 0 pixel word |
| w1_en | input | 1 | Window 1 enable |
| w1_fmt | input | 2 | Window 1 format code |
| w1_x | input | COORD_W | Window 1 origin column |
| w1_y | input | COORD_W | Window 1 origin row |
| w1_w | input | COORD_W | Window 1 width |
| w1_h | input | COORD_W | Window 1 height |
| w1_pix | input | 32 | Window 1 pixel word |
| key_en | input | 1 | Window 1 colour key enable |
| key_rgb | input | 24 | Window 1 key colour, R in [23:16] |
| out_valid | output | 1 | Output colour is valid |
| out_rgb | output | 24 | Composited colour, R in [23:16] |

## Verification
The bench builds the block with COORD_W at 8 and CONST_ALPHA at its default of 0xFF. The narrow coordinate width lets random windows reach the right and bottom of the coordinate space, so corners that fall past the last column or row are exercised alongside ordinary edges. The opaque constant alpha makes the non-alpha formats reproduce their colour exactly, while the alpha formats drive the rounding of the blend at 0x00, 0xFF and values in between.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int CH_W     = 8;
    localparam int FMT_W    = 2;
    localparam int FMT_HASA = 0;
    localparam int FMT_ALOW = 1;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;
endpackage

// File: rtl/ovl_rect.sv
module ovl_rect #(
    parameter int COORD_W = 12
) (
    input  logic               en,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] siz_w,
    input  logic [COORD_W-1:0] siz_h,
    output logic               hit
);
    localparam int EW = COORD_W + 1;

    logic [EW-1:0] sum_x, sum_y, last_x, last_y;

    always_comb begin
        sum_x  = {1'b0, org_x} + {1'b0, siz_w};
        sum_y  = {1'b0, org_y} + {1'b0, siz_h};
        last_x = (sum_x == '0) ? '0 : sum_x - EW'(1);
        last_y = (sum_y == '0) ? '0 : sum_y - EW'(1);
        hit    = en
              && ({1'b0, pos_x} >= {1'b0, org_x}) && ({1'b0, pos_x} <= last_x)
              && ({1'b0, pos_y} >= {1'b0, org_y}) && ({1'b0, pos_y} <= last_y);
    end
endmodule

// File: rtl/ovl_unpack.sv
module ovl_unpack
    import ovl_pkg::*;
#(
    parameter int              PIX_W       = 32,
    parameter logic [CH_W-1:0] CONST_ALPHA = 8'hFF
) (
    input  logic [PIX_W-1:0] word,
    input  logic [FMT_W-1:0] fmt,
    output rgb_t             rgb,
    output logic [CH_W-1:0]  alpha
);
    localparam int COL_W = 3 * CH_W;

    logic [CH_W-1:0] a_raw;

    always_comb begin
        if (fmt[FMT_ALOW]) begin
            rgb   = word[PIX_W-1 -: COL_W];
            a_raw = word[CH_W-1:0];
        end else begin
            rgb   = word[COL_W-1:0];
            a_raw = word[PIX_W-1 -: CH_W];
        end
        alpha = fmt[FMT_HASA] ? a_raw : CONST_ALPHA;
    end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
    import ovl_pkg::*;
(
    input  logic [CH_W-1:0] alpha,
    input  rgb_t            top,
    input  rgb_t            bot,
    output rgb_t            mix
);
    localparam int          AW   = 2 * CH_W + 1;
    localparam logic [AW-1:0] FULL = AW'((1 << CH_W) - 1);
    localparam logic [AW-1:0] HALF = AW'((1 << (CH_W - 1)) - 1);

    logic [2:0][CH_W-1:0] top_v, bot_v, mix_v;

    assign top_v = top;
    assign bot_v = bot;
    assign mix   = mix_v;

    for (genvar c = 0; c < 3; c++) begin : g_ch
        logic [AW-1:0] acc;
        always_comb begin
            acc = AW'(alpha) * AW'(top_v[c])
                + (FULL - AW'(alpha)) * AW'(bot_v[c])
                + HALF;
            mix_v[c] = CH_W'(acc / FULL);
        end
    end
endmodule

// File: rtl/overlay_mixer.sv
module overlay_mixer
    import ovl_pkg::*;
#(
    parameter int              COORD_W     = 12,
    parameter int              PIX_W       = 32,
    parameter logic [CH_W-1:0] CONST_ALPHA = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic               w0_en,
    input  logic [1:0]         w0_fmt,
    input  logic [COORD_W-1:0] w0_x,
    input  logic [COORD_W-1:0] w0_y,
    input  logic [COORD_W-1:0] w0_w,
    input  logic [COORD_W-1:0] w0_h,
    input  logic [PIX_W-1:0]   w0_pix,
    input  logic               w1_en,
    input  logic [1:0]         w1_fmt,
    input  logic [COORD_W-1:0] w1_x,
    input  logic [COORD_W-1:0] w1_y,
    input  logic [COORD_W-1:0] w1_w,
    input  logic [COORD_W-1:0] w1_h,
    input  logic [PIX_W-1:0]   w1_pix,
    input  logic               key_en,
    input  logic [23:0]        key_rgb,
    output logic               out_valid,
    output logic [23:0]        out_rgb
);
    localparam int NWIN    = 2;
    localparam int TOP_WIN = NWIN - 1;

    logic [NWIN-1:0]                w_en;
    logic [NWIN-1:0][FMT_W-1:0]     w_fmt;
    logic [NWIN-1:0][COORD_W-1:0]   w_x, w_y, w_w, w_h;
    logic [NWIN-1:0][PIX_W-1:0]     w_pix;

    assign w_en  = {w1_en,  w0_en};
    assign w_fmt = {w1_fmt, w0_fmt};
    assign w_x   = {w1_x,   w0_x};
    assign w_y   = {w1_y,   w0_y};
    assign w_w   = {w1_w,   w0_w};
    assign w_h   = {w1_h,   w0_h};
    assign w_pix = {w1_pix, w0_pix};

    logic [NWIN-1:0] hit, keyed, covers;
    rgb_t            win_rgb   [NWIN];
    logic [CH_W-1:0] win_alpha [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        ovl_rect #(.COORD_W(COORD_W)) u_rect (
            .en    (w_en[w]),
            .pos_x (pos_x),
            .pos_y (pos_y),
            .org_x (w_x[w]),
            .org_y (w_y[w]),
            .siz_w (w_w[w]),
            .siz_h (w_h[w]),
            .hit   (hit[w])
        );

        ovl_unpack #(.PIX_W(PIX_W), .CONST_ALPHA(CONST_ALPHA)) u_unpack (
            .word  (w_pix[w]),
            .fmt   (w_fmt[w]),
            .rgb   (win_rgb[w]),
            .alpha (win_alpha[w])
        );

        if (w == TOP_WIN) begin : g_key
            assign keyed[w] = key_en && (win_rgb[w] == rgb_t'(key_rgb));
        end else begin : g_nokey
            assign keyed[w] = 1'b0;
        end

        assign covers[w] = hit[w] && !keyed[w];
    end

    rgb_t base_mix, top_mix, base_rgb, final_rgb;

    ovl_blend u_blend_base (
        .alpha (win_alpha[0]),
        .top   (win_rgb[0]),
        .bot   ('0),
        .mix   (base_mix)
    );

    ovl_blend u_blend_top (
        .alpha (win_alpha[TOP_WIN]),
        .top   (win_rgb[TOP_WIN]),
        .bot   (base_rgb),
        .mix   (top_mix)
    );

    always_comb begin
        base_rgb  = covers[0]       ? base_mix : '0;
        final_rgb = covers[TOP_WIN] ? top_mix  : base_rgb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            out_rgb   <= final_rgb;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    uncovered_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!covers[0] && !covers[TOP_WIN]) |=> (out_rgb == '0));

    // R4
    top_opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (covers[TOP_WIN] && win_alpha[TOP_WIN] == 8'hFF)
        |=> (out_rgb == $past(win_rgb[TOP_WIN])));

    // R8
    key_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[TOP_WIN] && key_en && win_rgb[TOP_WIN] == rgb_t'(key_rgb) && !hit[0])
        |=> (out_rgb == '0));
endmodule

// File: tb/sim_overlay_mixer.sv
module sim_overlay_mixer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] pos_x = '0, pos_y = '0;
    logic          w0_en = 1'b0, w1_en = 1'b0;
    logic [1:0]    w0_fmt = '0, w1_fmt = '0;
    logic [CW-1:0] w0_x = '0, w0_y = '0, w0_w = '0, w0_h = '0;
    logic [CW-1:0] w1_x = '0, w1_y = '0, w1_w = '0, w1_h = '0;
    logic [31:0]   w0_pix = '0, w1_pix = '0;
    logic          key_en = 1'b0;
    logic [23:0]   key_rgb = '0;
    logic          out_valid;
    logic [23:0]   out_rgb;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    overlay_mixer #(.COORD_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pos_x(pos_x), .pos_y(pos_y),
        .w0_en(w0_en), .w0_fmt(w0_fmt), .w0_x(w0_x), .w0_y(w0_y),
        .w0_w(w0_w), .w0_h(w0_h), .w0_pix(w0_pix),
        .w1_en(w1_en), .w1_fmt(w1_fmt), .w1_x(w1_x), .w1_y(w1_y),
        .w1_w(w1_w), .w1_h(w1_h), .w1_pix(w1_pix),
        .key_en(key_en), .key_rgb(key_rgb),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic int corner(int p, int s);
        if (p + s == 0) return 0;
        return p + s - 1;
    endfunction

    function automatic bit inside_win(int en, int x, int y, int w, int h);
        int px = int'(pos_x);
        int py = int'(pos_y);
        return en != 0 && px >= x && px <= corner(x, w) && py >= y && py <= corner(y, h);
    endfunction

    // R5 unpack: returns {alpha, r, g, b}
    function automatic logic [31:0] unpack(logic [1:0] fmt, logic [31:0] pix);
        logic [23:0] col;
        logic [7:0]  a;
        if (fmt[1]) begin col = pix[31:8];  a = pix[7:0];   end
        else        begin col = pix[23:0];  a = pix[31:24]; end
        if (!fmt[0]) a = 8'hFF;
        return {a, col};
    endfunction

    function automatic logic [23:0] mixc(logic [7:0] a, logic [23:0] t, logic [23:0] b);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int ai = int'(a);
            int ti = int'(t[c*8 +: 8]);
            int bi = int'(b[c*8 +: 8]);
            r[c*8 +: 8] = 8'((ai * ti + (255 - ai) * bi + 127) / 255);
        end
        return r;
    endfunction

    function automatic logic [23:0] model();
        logic [31:0] u0v = unpack(w0_fmt, w0_pix);
        logic [31:0] u1v = unpack(w1_fmt, w1_pix);
        logic [23:0] acc = 24'h0;
        bit c0 = inside_win(int'(w0_en), int'(w0_x), int'(w0_y), int'(w0_w), int'(w0_h));
        bit c1 = inside_win(int'(w1_en), int'(w1_x), int'(w1_y), int'(w1_w), int'(w1_h));
        if (key_en && u1v[23:0] == key_rgb) c1 = 1'b0;
        if (c0) acc = mixc(u0v[31:24], u0v[23:0], 24'h0);
        if (c1) acc = mixc(u1v[31:24], u1v[23:0], acc);
        return acc;
    endfunction

    task automatic step(input string req);
        logic [23:0] exp_rgb = model();
        logic        exp_v   = in_valid;
        @(posedge clk); #1;
        checks++;
        if (out_rgb !== exp_rgb || out_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: actual rgb=%h valid=%b expected rgb=%h valid=%b",
                     req, out_rgb, out_valid, exp_rgb, exp_v);
        end
    endtask

    task automatic at(input int x, input int y);
        pos_x = CW'(x); pos_y = CW'(y);
    endtask

    task automatic win0(input bit en, input logic [1:0] f, input int x, input int y,
                        input int w, input int h, input logic [31:0] p);
        w0_en = en; w0_fmt = f; w0_x = CW'(x); w0_y = CW'(y);
        w0_w = CW'(w); w0_h = CW'(h); w0_pix = p;
    endtask

    task automatic win1(input bit en, input logic [1:0] f, input int x, input int y,
                        input int w, input int h, input logic [31:0] p);
        w1_en = en; w1_fmt = f; w1_x = CW'(x); w1_y = CW'(y);
        w1_w = CW'(w); w1_h = CW'(h); w1_pix = p;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL R10 watchdog: actual run still busy, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10 reset state: outputs held at zero while reset is low
        win0(1, 2'b00, 0, 0, 10, 10, 32'h00_AA_BB_CC);
        at(1, 1);
        in_valid = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
            errors++;
            $display("FAIL R10 reset: actual rgb=%h valid=%b expected rgb=000000 valid=0",
                     out_rgb, out_valid);
        end
        rst_n = 1'b1;
        in_valid = 1'b0;
        win0(0, 2'b00, 0, 0, 0, 0, 32'h0);
        step("R10 first cycle");

        in_valid = 1'b1;
        // R3 nothing enabled
        at(5, 5); step("R3 all windows off");
        win1(0, 2'b00, 0, 0, 50, 50, 32'h00_123456);
        step("R3 disabled window ignored");

        // R2 edges of window 0 at (10,20) size 5x4 -> last (14,23); alpha byte junk R5
        win0(1, 2'b00, 10, 20, 5, 4, 32'h37_102030);
        at(10, 20); step("R2 top-left corner");
        at(14, 23); step("R2 bottom-right corner");
        at(15, 23); step("R2 one past right");
        at(14, 24); step("R2 one past bottom");
        at(9, 20);  step("R2 one before left");
        at(12, 19); step("R2 one above top");

        // R1 zero-size window at origin
        win0(1, 2'b00, 0, 0, 0, 0, 32'h00_FF8000);
        at(0, 0); step("R1 zero corner covers origin");
        at(1, 0); step("R1 zero corner column 1");
        at(0, 1); step("R1 zero corner row 1");
        // R1 corner at last coordinate
        win0(1, 2'b00, 250, 250, 6, 6, 32'h00_010203);
        at(255, 255); step("R1 corner at last coordinate");

        // R4 opaque window 1 over window 0
        win0(1, 2'b00, 0, 0, 100, 100, 32'h00_112233);
        win1(1, 2'b00, 40, 40, 10, 10, 32'h00_AABBCC);
        at(45, 45); step("R4 top window wins");
        at(39, 45); step("R4 base visible beside top");

        // R5 low-alpha-position opaque format
        win1(1, 2'b10, 40, 40, 10, 10, 32'hDEADBE_5A);
        at(41, 41); step("R5 padding in low byte");

        // R6 per-pixel alpha blends
        win1(1, 2'b01, 40, 40, 10, 10, 32'h80_F01008);
        step("R6 high alpha byte 0x80");
        win1(1, 2'b11, 40, 40, 10, 10, 32'h20C0FF_40);
        step("R6 low alpha byte 0x40");
        win1(1, 2'b01, 40, 40, 10, 10, 32'h00_FFFFFF);
        step("R6 alpha zero shows base");
        win1(1, 2'b01, 40, 40, 10, 10, 32'hFF_0F0F0F);
        step("R6 alpha full shows top");

        // R7 window 0 alpha over black
        win1(0, 2'b00, 0, 0, 0, 0, 32'h0);
        win0(1, 2'b01, 0, 0, 100, 100, 32'h80_FF7F01);
        at(3, 3); step("R7 base blends with black");

        // R8 colour key
        win0(1, 2'b00, 0, 0, 100, 100, 32'h00_112233);
        win1(1, 2'b00, 40, 40, 10, 10, 32'h00_00FF00);
        key_en = 1'b1; key_rgb = 24'h00FF00;
        at(42, 42); step("R8 key match reveals base");
        key_rgb = 24'h00FF01;
        step("R8 key mismatch keeps top");
        win0(0, 2'b00, 0, 0, 0, 0, 32'h0);
        key_rgb = 24'h00FF00;
        step("R8 key match over nothing is black");

        // R9 key disabled with all-ones key
        key_en = 1'b0; key_rgb = 24'hFFFFFF;
        win1(1, 2'b00, 40, 40, 10, 10, 32'h00_FFFFFF);
        step("R9 disabled key leaves white");

        // R10 invalid input passes through as invalid
        in_valid = 1'b0;
        step("R10 valid low");
        in_valid = 1'b1;
        step("R10 valid high again");

        // mixed random sweep
        for (int i = 0; i < 400; i++) begin
            win0($urandom_range(1) != 0, 2'($urandom_range(3)), $urandom_range(200),
                 $urandom_range(200), $urandom_range(80), $urandom_range(80), $urandom);
            win1($urandom_range(1) != 0, 2'($urandom_range(3)), $urandom_range(220),
                 $urandom_range(220), $urandom_range(60), $urandom_range(60),
                 ($urandom_range(3) == 0) ? {8'h00, key_rgb} : $urandom);
            key_en   = $urandom_range(1) != 0;
            key_rgb  = ($urandom_range(1) != 0) ? w1_pix[23:0] : 24'($urandom);
            in_valid = $urandom_range(3) != 0;
            at($urandom_range(255), $urandom_range(255));
            step("R6 R8 random sweep");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule